// File: doc/BRIEF.md
# Multidrop Receiver Sleep and Wakeup Controller

On a shared serial line with several receivers, a node that sees that a message is addressed elsewhere can put its receiver to sleep. This block holds that sleep bit and controls the receiver's status flags. Software sets the bit. While the bit is set, the block stops every receive-status update, so the rest of the unwanted message never reaches software. Hardware clears the bit again on one of two selectable wake events.

In idle-line mode, the receiver wakes when the line falls idle after a message. The first frame of the next message is then taken normally. In address-mark mode, every frame carries a top bit that marks it as an address (1) or as data (0). A sleeping receiver wakes on an address frame and passes that frame on to software, which compares it against the node identity.

The receiver supplies a one-cycle pulse for each completed frame, together with the two candidate top bits, and a one-cycle pulse when an idle line is detected. The block returns the sleep bit and two update strobes. One strobe tells the receiver to set its frame flags (receive-full and the error flags). The other tells it to set its idle flag.

Top module: `rwu_wakeup_ctrl`

## Requirements
- R1: While `rst` is high, and after it is released, `sleep` is 0.
- R2: A cycle with `sw_wr`=1 loads `sw_wdata` into `sleep` at the next clock edge. This write wins over a hardware wake event in the same cycle.
- R3: While awake, every `char_done` pulse gives `rx_flag_upd`=1 in the same cycle. While asleep, a frame that does not wake the receiver gives `rx_flag_upd`=0.
- R4: `idle_flag_upd` follows `line_idle` while `sleep`=0. It is 0 whenever `sleep`=1, including the idle pulse that wakes the receiver.
- R5: In idle-line mode (`wake_mode`=0), an idle pulse clears `sleep` at the next edge if at least one frame has completed since the sleep bit was last written.
- R6: In idle-line mode, an idle pulse with no completed frame since the last software write leaves `sleep` at 1.
- R7: In idle-line mode, completed frames never clear `sleep`, whatever their top bit.
- R8: In address-mark mode (`wake_mode`=1), a frame whose top bit is 1 clears `sleep` at the next edge and gives `rx_flag_upd`=1 in its own cycle.
- R9: In address-mark mode, frames whose top bit is 0 and idle pulses leave `sleep` at 1.
- R10: The top bit of a frame is `char_hi[0]` (data bit 7) when `char_long`=0, and `char_hi[1]` (bit 8) when `char_long`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_mode | input | 1 | 0 = idle-line wake, 1 = address-mark wake |
| char_long | input | 1 | 0 = 8-bit frames, 1 = 9-bit frames |
| sw_wr | input | 1 | Software write strobe for the sleep bit |
| sw_wdata | input | 1 | Value written to the sleep bit |
| char_done | input | 1 | One-cycle pulse per completed frame |
| char_hi | input | 2 | Frame bits {bit 8, bit 7} |
| line_idle | input | 1 | One-cycle pulse on idle-line detection |
| sleep | output | 1 | Current sleep bit |
| rx_flag_upd | output | 1 | Strobe: receiver may update its frame flags |
| idle_flag_upd | output | 1 | Strobe: receiver may set its idle flag |

## Verification
Assertions check the following on every cycle:
- that a software write lands one cycle later;
- that address frames wake a sleeping receiver and data frames do not;
- that both update strobes stay low while asleep, unless the frame is the waking address frame;
- that an idle pulse directly after a sleep write leaves the bit set.

Only the bench scenarios can show the following, because each is a history over several frames rather than a relation between two cycles:
- the top-bit selection for both frame lengths, across all bit pairs;
- a wake by idle line only after real activity;
- the write that collides with a wake event.

// File: rtl/rwu_pkg.sv
package rwu_pkg;

    typedef enum logic {
        WAKE_ON_IDLE = 1'b0,
        WAKE_ON_ADDR = 1'b1
    } wake_mode_e;

    typedef enum logic {
        CHAR_SHORT = 1'b0,
        CHAR_LONG  = 1'b1
    } char_len_e;

    localparam int HI_W = 2;

    typedef struct packed {
        logic done;
        logic msb;
    } rx_char_t;

    typedef struct packed {
        logic valid;
        logic value;
    } sw_write_t;

    function automatic logic pick_msb(input char_len_e len, input logic [HI_W-1:0] hi);
        return (len == CHAR_LONG) ? hi[1] : hi[0];
    endfunction

endpackage

// File: rtl/rwu_char_classify.sv
module rwu_char_classify
    import rwu_pkg::*;
(
    input  logic            char_done,
    input  logic [HI_W-1:0] char_hi,
    input  char_len_e       char_len,
    output rx_char_t        evt
);
    always_comb begin
        evt.done = char_done;
        evt.msb  = pick_msb(char_len, char_hi);
    end
endmodule

// File: rtl/rwu_activity_arm.sv
module rwu_activity_arm
    import rwu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sw_write_t sw,
    input  rx_char_t  evt,
    input  logic      line_idle,
    output logic      armed
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst)            armed_q <= 1'b0;
        else if (sw.valid)  armed_q <= 1'b0;
        else if (evt.done)  armed_q <= 1'b1;
        else if (line_idle) armed_q <= 1'b0;
    end

    assign armed = armed_q;

    // R6: a software write always leaves the tracker disarmed
    assert_write_disarms_R6: assert property (@(posedge clk) disable iff (rst)
        sw.valid |=> !armed_q);
endmodule

// File: rtl/rwu_wake_decode.sv
module rwu_wake_decode
    import rwu_pkg::*;
(
    input  wake_mode_e mode,
    input  rx_char_t   evt,
    input  logic       armed,
    input  logic       line_idle,
    output logic       wake_req
);
    always_comb begin
        unique case (mode)
            WAKE_ON_ADDR: wake_req = evt.done & evt.msb;
            default:      wake_req = line_idle & armed;
        endcase
    end
endmodule

// File: rtl/rwu_sleep_reg.sv
module rwu_sleep_reg
    import rwu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sw_write_t sw,
    input  logic      wake_req,
    output logic      sleep_q
);
    always_ff @(posedge clk) begin
        if (rst)           sleep_q <= 1'b0;
        else if (sw.valid) sleep_q <= sw.value;
        else if (wake_req) sleep_q <= 1'b0;
    end

    assert_reset_awake_R1: assert property (@(posedge clk)
        rst |=> !sleep_q);

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        sw.valid |=> sleep_q == $past(sw.value));

    assert_stays_without_event_R2: assert property (@(posedge clk) disable iff (rst)
        (!sw.valid && !wake_req) |=> sleep_q == $past(sleep_q));
endmodule

// File: rtl/rwu_wakeup_ctrl.sv
module rwu_wakeup_ctrl
    import rwu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wake_mode,
    input  logic            char_long,
    input  logic            sw_wr,
    input  logic            sw_wdata,
    input  logic            char_done,
    input  logic [HI_W-1:0] char_hi,
    input  logic            line_idle,
    output logic            sleep,
    output logic            rx_flag_upd,
    output logic            idle_flag_upd
);
    wake_mode_e mode;
    char_len_e  len;
    sw_write_t  sw;
    rx_char_t   evt;
    logic       armed;
    logic       wake_req;
    logic       sleep_q;

    assign mode     = wake_mode_e'(wake_mode);
    assign len      = char_len_e'(char_long);
    assign sw.valid = sw_wr;
    assign sw.value = sw_wdata;

    rwu_char_classify u_classify (
        .char_done (char_done),
        .char_hi   (char_hi),
        .char_len  (len),
        .evt       (evt)
    );

    rwu_activity_arm u_arm (
        .clk       (clk),
        .rst       (rst),
        .sw        (sw),
        .evt       (evt),
        .line_idle (line_idle),
        .armed     (armed)
    );

    rwu_wake_decode u_decode (
        .mode      (mode),
        .evt       (evt),
        .armed     (armed),
        .line_idle (line_idle),
        .wake_req  (wake_req)
    );

    rwu_sleep_reg u_sleep (
        .clk      (clk),
        .rst      (rst),
        .sw       (sw),
        .wake_req (wake_req),
        .sleep_q  (sleep_q)
    );

    assign sleep         = sleep_q;
    assign rx_flag_upd   = evt.done & (~sleep_q | ((mode == WAKE_ON_ADDR) & wake_req));
    assign idle_flag_upd = line_idle & ~sleep_q;

    assert_awake_frames_pass_R3: assert property (@(posedge clk) disable iff (rst)
        (char_done && !sleep) |-> rx_flag_upd);

    assert_idle_gated_R4: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !idle_flag_upd);

    assert_addr_wakes_R8: assert property (@(posedge clk) disable iff (rst)
        (wake_mode && sleep && char_done && evt.msb && !sw_wr) |=> !sleep);

    assert_addr_frame_passes_R8: assert property (@(posedge clk) disable iff (rst)
        (wake_mode && char_done && evt.msb) |-> rx_flag_upd);

    assert_data_blocked_R9: assert property (@(posedge clk) disable iff (rst)
        (wake_mode && sleep && char_done && !evt.msb) |-> !rx_flag_upd);

    assert_addr_mode_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (wake_mode && sleep && !sw_wr && !(char_done && evt.msb)) |=> sleep);

    assert_idle_frames_blocked_R7: assert property (@(posedge clk) disable iff (rst)
        (!wake_mode && sleep && char_done) |-> !rx_flag_upd);

    assert_stale_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (!wake_mode && $past(sw_wr && sw_wdata) && line_idle && !char_done && !sw_wr) |=> sleep);
endmodule

// File: tb/test_rwu_wakeup_ctrl.sv
`timescale 1ns/1ps
module test_rwu_wakeup_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wake_mode = 1'b0;
    logic       char_long = 1'b0;
    logic       sw_wr = 1'b0;
    logic       sw_wdata = 1'b0;
    logic       char_done = 1'b0;
    logic [1:0] char_hi = 2'b00;
    logic       line_idle = 1'b0;
    logic       sleep;
    logic       rx_flag_upd;
    logic       idle_flag_upd;

    int errors = 0;
    int checks = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    rwu_wakeup_ctrl i_rwu_wakeup_ctrl (
        .clk(clk), .rst(rst), .wake_mode(wake_mode), .char_long(char_long),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata), .char_done(char_done),
        .char_hi(char_hi), .line_idle(line_idle), .sleep(sleep),
        .rx_flag_upd(rx_flag_upd), .idle_flag_upd(idle_flag_upd)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic sw_write(input logic v);
        @(negedge clk);
        sw_wr = 1'b1; sw_wdata = v;
        @(negedge clk);
        sw_wr = 1'b0;
    endtask

    task automatic frame(input logic [1:0] hi, input logic exp_upd, input string req);
        @(negedge clk);
        char_done = 1'b1; char_hi = hi;
        #1 chk(req, rx_flag_upd, exp_upd);
        @(negedge clk);
        char_done = 1'b0;
    endtask

    task automatic idle_pulse(input logic exp_upd, input string req);
        @(negedge clk);
        line_idle = 1'b1;
        #1 chk(req, idle_flag_upd, exp_upd);
        @(negedge clk);
        line_idle = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 sleep during reset", sleep, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sleep after reset", sleep, 1'b0);
        idle_pulse(1'b1, "R4 idle flag while awake");

        // Sweep: mode x length x top bits x initial sleep state
        for (int m = 0; m < 2; m++) begin
            for (int l = 0; l < 2; l++) begin
                for (int h = 0; h < 4; h++) begin
                    for (int s = 0; s < 2; s++) begin
                        logic [1:0] hi;
                        logic msb, exp_upd, exp_sleep;
                        hi = 2'(h);
                        @(negedge clk);
                        wake_mode = m[0]; char_long = l[0];
                        sw_write(s[0]);
                        chk("R2 write lands", sleep, s[0]);
                        msb = l[0] ? hi[1] : hi[0];               // R10
                        exp_upd = !s[0] || (m[0] && msb);
                        exp_sleep = s[0] && !(m[0] && msb);
                        frame(hi, exp_upd, m[0] ? "R8/R9/R10 addr-mode frame strobe" : "R3/R7 idle-mode frame strobe");
                        chk(m[0] ? "R8/R9/R10 sleep after frame" : "R7 sleep after frame", sleep, exp_sleep);
                        if (exp_sleep) begin
                            idle_pulse(1'b0, "R4 idle flag blocked while asleep");
                            chk(m[0] ? "R9 idle ignored in addr mode" : "R5 idle wakes after activity",
                                sleep, m[0] ? 1'b1 : 1'b0);
                        end
                    end
                end
            end
        end

        // R6: stale idle right after the sleep write
        @(negedge clk);
        wake_mode = 1'b0; char_long = 1'b0;
        sw_write(1'b1);
        idle_pulse(1'b0, "R4 idle flag blocked");
        chk("R6 stale idle keeps sleep", sleep, 1'b1);
        frame(2'b11, 1'b0, "R3 asleep frame blocked");
        chk("R7 frame does not wake", sleep, 1'b1);
        idle_pulse(1'b0, "R4 waking idle pulse not flagged");
        chk("R5 idle after frame wakes", sleep, 1'b0);
        frame(2'b00, 1'b1, "R5 next message first frame passes");

        // R6: re-writing sleep disarms earlier activity
        sw_write(1'b1);
        frame(2'b00, 1'b0, "R3 blocked");
        sw_write(1'b1);
        idle_pulse(1'b0, "R4 blocked");
        chk("R6 rewrite disarms", sleep, 1'b1);

        // R2: write collides with an address wake
        @(negedge clk);
        wake_mode = 1'b1;
        @(negedge clk);
        sw_wr = 1'b1; sw_wdata = 1'b1; char_done = 1'b1; char_hi = 2'b01;
        #1 chk("R8 address frame strobe on collision", rx_flag_upd, 1'b1);
        @(negedge clk);
        sw_wr = 1'b0; char_done = 1'b0;
        chk("R2 write wins over wake", sleep, 1'b1);
        sw_write(1'b0);
        chk("R2 software clear", sleep, 1'b0);
        idle_pulse(1'b1, "R4 idle flag awake in addr mode");

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule